// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block sits between the digital control of a half-bridge and its two gate drivers. It receives a high-side command, a low-side command, an active-low halt input and one supply-good flag per side. It produces one gate enable per switch. It assumes all inputs are already synchronised to its clock.

Several rules shape the outputs. Commands on both sides at the same time are refused. The halt input blocks everything. Each side needs its own supply flag to be good. On the high side, any level (high or low) shorter than a minimum number of cycles is lengthened to that minimum. The high side also carries a transfer latency that models the crossing of an isolation barrier. The low side has no stretching. Instead it passes through a delay line sized so that both channels switch the same number of cycles after their commands. The interlock is decided on these aligned, already-stretched command values, so the two enables can never be on in the same cycle.

Top module: `hb_gate_interlock`

## Requirements
- R1: A synchronous active-high `rst` turns both gates off at the following edge. It also clears the high-side stretch timer and every stage of both delay paths, so a command seen before reset never reaches a gate afterwards.
- R2: When only `cmd_hi` is high, only `gate_hi` turns on. When only `cmd_lo` is high, only `gate_lo` turns on. This requires halt released and both supplies good.
- R3: When both commands are high at the aligned interlock point, both gates stay off. When one of them drops, the other side's gate turns on. `gate_hi` and `gate_lo` are never both 1.
- R4: While `halt_n` is 0, both gates are 0 from the next clock edge and the commands have no effect. Once `halt_n` returns to 1, the gates follow the aligned commands again from the next edge.
- R5: `gate_hi` is 1 only if `good_hi` was 1 at the previous edge, and `gate_lo` likewise depends on `good_lo`. Dropping one side's flag turns that side off at the next edge and leaves the other side unaffected.
- R6: On the high side, any high pulse or low gap shorter than `MIN_W` cycles appears at `gate_hi` exactly `MIN_W` cycles long. A level lasting `MIN_W` cycles or more keeps its length.
- R7: The low side does no stretching. A `cmd_lo` pulse of N cycles gives a `gate_lo` pulse of N cycles, including N = 1.
- R8: Both channels turn on and off exactly `XFER_DLY + 2` clock edges after their command changes. This comes from one stretch register plus `XFER_DLY` transfer stages on the high side, `XFER_DLY + 1` delay stages on the low side, and one output register on each side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 1 | High-side switch command, 1 = on |
| cmd_lo | input | 1 | Low-side switch command, 1 = on |
| halt_n | input | 1 | Halt, active low; 0 forces both gates off |
| good_hi | input | 1 | High-side supply good, 1 = good |
| good_lo | input | 1 | Low-side supply good, 1 = good |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
The halt and supply-good effects are due one edge after the input changes. Command effects are due `XFER_DLY + 2` edges after the command changes, which is four with the default parameters. The bench drives inputs one time unit after a rising edge and samples the outputs at the same point after the edge that completes that count. It also checks the sample one edge earlier to confirm that nothing arrives early. Stretch and pass-through widths are measured by counting 1 or 0 samples over a window wide enough to hold the whole delayed pulse. This makes the width checks independent of start time. A long random run then checks mutual exclusion and both one-edge gating rules on every cycle.

// File: rtl/hb_gate_interlock.sv
module hb_gate_interlock #(
  parameter int MIN_W    = 4,
  parameter int XFER_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_hi,
  input  logic cmd_lo,
  input  logic halt_n,
  input  logic good_hi,
  input  logic good_lo,
  output logic gate_hi,
  output logic gate_lo
);

  localparam int CW       = $clog2(MIN_W + 1);
  localparam int LO_DEPTH = XFER_DLY + 1;

  logic                hi_st;
  logic [CW-1:0]       hold;
  logic [XFER_DLY-1:0] hi_xfer;
  logic [LO_DEPTH-1:0] lo_dly;
  logic                hi_at, lo_at;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_st <= 1'b0;
      hold  <= '0;
    end else if (hold != '0) begin
      hold <= hold - CW'(1);
    end else if (cmd_hi != hi_st) begin
      hi_st <= cmd_hi;
      hold  <= CW'(MIN_W - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_xfer <= '0;
      lo_dly  <= '0;
    end else begin
      hi_xfer[0] <= hi_st;
      for (int i = 1; i < XFER_DLY; i++) hi_xfer[i] <= hi_xfer[i-1];
      lo_dly[0] <= cmd_lo;
      for (int i = 1; i < LO_DEPTH; i++) lo_dly[i] <= lo_dly[i-1];
    end
  end

  assign hi_at = hi_xfer[XFER_DLY-1];
  assign lo_at = lo_dly[LO_DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= halt_n & good_hi & hi_at & ~lo_at;
      gate_lo <= halt_n & good_lo & lo_at & ~hi_at;
    end
  end

endmodule

// File: rtl/hb_gate_interlock_chk.sv
module hb_gate_interlock_chk #(
  parameter int MIN_W    = 4,
  parameter int XFER_DLY = 2
) (
  input logic clk,
  input logic rst,
  input logic halt_n,
  input logic good_hi,
  input logic good_lo,
  input logic gate_hi,
  input logic gate_lo,
  input logic hi_st
);

  int unsigned run;
  logic        prev, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 0;
      prev <= 1'b0;
      seen <= 1'b0;
    end else begin
      prev <= hi_st;
      if (hi_st != prev) begin
        run  <= 1;
        seen <= 1'b1;
      end else if (run < 32'(MIN_W + XFER_DLY + 8)) begin
        run <= run + 1;
      end
    end
  end

  // R1
  reset_off_chk: assert property (@(posedge clk) rst |=> (!gate_hi && !gate_lo));

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(gate_hi && gate_lo));

  // R4
  halt_off_chk: assert property (@(posedge clk) disable iff (rst) !halt_n |=> (!gate_hi && !gate_lo));

  // R5
  good_hi_chk: assert property (@(posedge clk) disable iff (rst) !good_hi |=> !gate_hi);

  // R5
  good_lo_chk: assert property (@(posedge clk) disable iff (rst) !good_lo |=> !gate_lo);

  // R6
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    (seen && hi_st != prev) |-> (run >= 32'(MIN_W)));

endmodule

bind hb_gate_interlock hb_gate_interlock_chk #(.MIN_W(MIN_W), .XFER_DLY(XFER_DLY)) u_chk (
  .clk(clk), .rst(rst), .halt_n(halt_n), .good_hi(good_hi), .good_lo(good_lo),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .hi_st(hi_st)
);

// File: tb/sim_hb_gate_interlock.sv
module sim_hb_gate_interlock;
  localparam int MIN_W = 4;
  localparam int XFER_DLY = 2;
  localparam int LAT = XFER_DLY + 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_hi = 1'b0, cmd_lo = 1'b0, halt_n = 1'b1, good_hi = 1'b1, good_lo = 1'b1;
  logic gate_hi, gate_lo;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  hb_gate_interlock #(.MIN_W(MIN_W), .XFER_DLY(XFER_DLY)) u0 (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .halt_n(halt_n),
    .good_hi(good_hi), .good_lo(good_lo), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  always #10 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_v(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic hi_pulse(input int w, input int exp, input string req);
    int ones = 0;
    cmd_hi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (i == w) cmd_hi = 1'b0;
      tick();
      if (gate_hi) ones++;
    end
    expect_v(req, ones, exp);
  endtask

  task automatic lo_pulse(input int w, input int exp, input string req);
    int ones = 0;
    cmd_lo = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i == w) cmd_lo = 1'b0;
      tick();
      if (gate_lo) ones++;
    end
    expect_v(req, ones, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    int hits;
    int zeros;
    int v_ex, v_halt, v_ghi, v_glo;
    logic p_halt, p_ghi, p_glo;

    tick(3);
    expect_v("R1 gate_hi in reset", gate_hi, 0);
    expect_v("R1 gate_lo in reset", gate_lo, 0);

    // R1: reset must flush a command already in the delay line
    rst = 1'b0;
    cmd_lo = 1'b1;
    tick(2);
    rst = 1'b1;
    cmd_lo = 1'b0;
    tick();
    rst = 1'b0;
    hits = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (gate_lo) hits++;
    end
    expect_v("R1 delay line cleared", hits, 0);

    // R2 / R8 high side alone
    cmd_hi = 1'b1;
    tick(LAT - 1);
    expect_v("R8 gate_hi not early", gate_hi, 0);
    tick();
    expect_v("R2 gate_hi on", gate_hi, 1);
    expect_v("R2 gate_lo stays off", gate_lo, 0);
    cmd_hi = 1'b0;
    tick(LAT - 1);
    expect_v("R8 gate_hi off not early", gate_hi, 1);
    tick();
    expect_v("R8 gate_hi off latency", gate_hi, 0);
    tick(8);

    // R2 / R8 low side alone
    cmd_lo = 1'b1;
    tick(LAT - 1);
    expect_v("R8 gate_lo not early", gate_lo, 0);
    tick();
    expect_v("R2 gate_lo on", gate_lo, 1);
    expect_v("R2 gate_hi stays off", gate_hi, 0);

    // R3 both commands
    cmd_hi = 1'b1;
    tick(LAT);
    expect_v("R3 lo blocked", gate_lo, 0);
    expect_v("R3 hi blocked", gate_hi, 0);
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (gate_hi || gate_lo) hits++;
    end
    expect_v("R3 both held off", hits, 0);
    cmd_lo = 1'b0;
    tick(LAT);
    expect_v("R3 hi after lo drops", gate_hi, 1);
    cmd_hi = 1'b0;
    tick(8);

    // R4 halt
    cmd_hi = 1'b1;
    tick(6);
    halt_n = 1'b0;
    tick();
    expect_v("R4 gate_hi off one edge", gate_hi, 0);
    cmd_hi = 1'b0;
    cmd_lo = 1'b1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (gate_hi || gate_lo) hits++;
    end
    expect_v("R4 commands ignored", hits, 0);
    halt_n = 1'b1;
    tick();
    expect_v("R4 release one edge", gate_lo, 1);

    // R5 supply flags
    good_lo = 1'b0;
    tick();
    expect_v("R5 gate_lo drops", gate_lo, 0);
    good_lo = 1'b1;
    good_hi = 1'b0;
    tick();
    expect_v("R5 gate_lo unaffected by good_hi", gate_lo, 1);
    cmd_lo = 1'b0;
    cmd_hi = 1'b1;
    tick(6);
    expect_v("R5 gate_hi held off", gate_hi, 0);
    good_hi = 1'b1;
    tick();
    expect_v("R5 gate_hi returns", gate_hi, 1);
    cmd_hi = 1'b0;
    tick(8);

    // R6 stretching on the high side
    hi_pulse(1, MIN_W, "R6 one-cycle pulse");
    hi_pulse(2, MIN_W, "R6 two-cycle pulse");
    hi_pulse(MIN_W + 2, MIN_W + 2, "R6 long pulse kept");
    cmd_hi = 1'b1;
    tick(10);
    cmd_hi = 1'b0;
    zeros = 0;
    for (int i = 0; i < 15; i++) begin
      tick();
      cmd_hi = 1'b1;
      if (!gate_hi) zeros++;
    end
    expect_v("R6 short gap stretched", zeros, MIN_W);
    cmd_hi = 1'b0;
    tick(10);

    // R7 low side passes short pulses
    lo_pulse(1, 1, "R7 one-cycle pulse");
    lo_pulse(2, 2, "R7 two-cycle pulse");

    // random run
    v_ex = 0; v_halt = 0; v_ghi = 0; v_glo = 0;
    p_halt = 1'b1; p_ghi = 1'b1; p_glo = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      cmd_hi = 1'($urandom_range(0, 1));
      cmd_lo = 1'($urandom_range(0, 1));
      halt_n = ($urandom_range(0, 9) != 0);
      good_hi = ($urandom_range(0, 11) != 0);
      good_lo = ($urandom_range(0, 11) != 0);
      p_halt = halt_n; p_ghi = good_hi; p_glo = good_lo;
      tick();
      if (gate_hi && gate_lo) v_ex++;
      if (!p_halt && (gate_hi || gate_lo)) v_halt++;
      if (!p_ghi && gate_hi) v_ghi++;
      if (!p_glo && gate_lo) v_glo++;
    end
    expect_v("R3 random overlap count", v_ex, 0);
    expect_v("R4 random halt leaks", v_halt, 0);
    expect_v("R5 random good_hi leaks", v_ghi, 0);
    expect_v("R5 random good_lo leaks", v_glo, 0);

    summary();
  end
endmodule